// File: doc/BRIEF.md
# Subarray Idle Power-Down Manager

This block watches a set of independently accessed memory subarrays and puts each one into a low-power state once it has gone unused long enough. Every subarray has its own idle counter and its own sleep state. The idle limit is set as a multiplier applied to the wake-up latency of the selected sleep mode, so one multiplier setting suits both modes. Two sleep depths exist. The shallow mode wakes in 3 cycles and saves about 5.5x background power. The deep mode wakes in 200 cycles and saves about 10x.

A request to a sleeping subarray starts a wake-up. Ready stays low for that subarray until the wake-up has run its full length. Subarrays are grouped into banks that share a row buffer, and each bank can serve only one access per cycle. When several awake subarrays in a bank request together, the lowest-numbered one wins. A saturating counter per subarray counts the cycles spent asleep. Any one of these counters can be read out through a select input, so that background energy savings can be estimated.

Top module: `sa_pwr_mgr`

## Requirements
- R1: While reset is high and on the first cycle after it, no subarray is asleep, all sleep outputs are 0, `req_ready` is 0 when no request is valid, and `rd_asleep` is 0.
- R2: With `cfg_deep`=0 and `cfg_mult`=M>0, an awake subarray with no valid request on M*3 consecutive clock edges shows `sleep_light`=1 after the M*3-th edge and not before. It stays asleep while no request arrives.
- R3: With `cfg_deep`=1 and `cfg_mult`=M>0, the same holds with M*200 idle edges, and the subarray shows `sleep_deep`=1.
- R4: A valid request on an awake subarray clears its idle count, so the idle edges must be consecutive.
- R5: With `cfg_mult`=0, no subarray enters a sleep state.
- R6: If a sleeping subarray samples a valid request on edge E, it wakes over the following W edges (W=3 for a light sleeper, W=200 for a deep one). Its `req_ready` is 0 until edge E+W and may be 1 from edge E+W on.
- R7: The sleep mode is captured when a subarray falls asleep. A later change of `cfg_deep` does not change a sleeping subarray's sleep output or its wake-up latency.
- R8: Subarrays i with the same i/4 form a bank. In each bank, `req_ready` is 1 for at most one subarray: the lowest-indexed one that is awake and has `req_valid`=1.
- R9: Each subarray's asleep counter rises by one on every edge on which that subarray is asleep, excluding wake-up cycles, and it saturates. After an edge, `rd_asleep` shows the value that the counter selected by `rd_sel` held before that edge.
- R10: A subarray that is asleep or waking never shows `req_ready`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | NUM_SUB | Request valid, one bit per subarray |
| req_ready | output | NUM_SUB | Access granted this cycle, one bit per subarray |
| cfg_deep | input | 1 | Sleep mode for awake subarrays: 0 light, 1 deep |
| cfg_mult | input | MULT_W | Idle limit as a multiple of the selected wake latency; 0 disables sleep |
| sleep_light | output | NUM_SUB | Subarray asleep in light mode |
| sleep_deep | output | NUM_SUB | Subarray asleep in deep mode |
| rd_sel | input | SEL_W | Selects which asleep counter to read |
| rd_asleep | output | CNT_W | Registered asleep-cycle count of the selected subarray |

## Verification
The bench checks the exact edge on which a subarray falls asleep. A design off by one in the idle compare would sleep a cycle early or late, or it would never sleep with a multiplier of 1. The wake-up is timed edge by edge in both modes. A design that asserted ready one cycle early, or that used the newly configured mode instead of the captured one, would be reported. Heavy same-bank contention shows whether the grant is unique and goes to the lowest index. A random phase with changing multiplier and mode compares the asleep counters against a model, which catches counting during wake-up or a readout with the wrong latency.

// File: rtl/sa_pwr_pkg.sv
package sa_pwr_pkg;
  typedef enum logic [1:0] {
    SA_AWAKE  = 2'd0,
    SA_ASLEEP = 2'd1,
    SA_WAKING = 2'd2
  } sa_state_e;
endpackage

// File: rtl/sa_pd_unit.sv
module sa_pd_unit
  import sa_pwr_pkg::*;
#(
  parameter int MULT_W     = 4,
  parameter int LIGHT_WAKE = 3,
  parameter int DEEP_WAKE  = 200,
  parameter int CNT_W      = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              req_valid,
  input  logic              cfg_deep,
  input  logic [MULT_W-1:0] cfg_mult,
  output logic              awake,
  output logic              sleep_light,
  output logic              sleep_deep,
  output logic [CNT_W-1:0]  asleep_cnt
);
  localparam int MAX_WAKE = (DEEP_WAKE > LIGHT_WAKE) ? DEEP_WAKE : LIGHT_WAKE;
  localparam int MAX_THR  = ((1 << MULT_W) - 1) * MAX_WAKE;
  localparam int IDLE_W   = $clog2(MAX_THR + 1);
  localparam int WAKE_W   = $clog2(MAX_WAKE + 1);
  localparam logic [IDLE_W-1:0] LIGHT_I    = IDLE_W'(LIGHT_WAKE);
  localparam logic [IDLE_W-1:0] DEEP_I     = IDLE_W'(DEEP_WAKE);
  localparam logic [WAKE_W-1:0] LIGHT_LAST = WAKE_W'(LIGHT_WAKE - 1);
  localparam logic [WAKE_W-1:0] DEEP_LAST  = WAKE_W'(DEEP_WAKE - 1);

  sa_state_e         st_q;
  logic [IDLE_W-1:0] idle_q;
  logic [IDLE_W-1:0] thr;
  logic [IDLE_W:0]   idle_nxt;
  logic [WAKE_W-1:0] wake_q;
  logic [WAKE_W-1:0] wake_last;
  logic              mode_q;
  logic [CNT_W-1:0]  cnt_q;

  // Threshold follows the live configuration; only awake subarrays use it.
  assign thr       = IDLE_W'(cfg_mult) * (cfg_deep ? DEEP_I : LIGHT_I);
  assign idle_nxt  = {1'b0, idle_q} + (IDLE_W+1)'(1);
  // Wake length follows the mode captured on entry to sleep.
  assign wake_last = mode_q ? DEEP_LAST : LIGHT_LAST;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q   <= SA_AWAKE;
      idle_q <= '0;
      wake_q <= '0;
      mode_q <= 1'b0;
      cnt_q  <= '0;
    end else begin
      case (st_q)
        SA_AWAKE: begin
          if (req_valid || thr == '0) begin
            idle_q <= '0;
          end else if (idle_nxt >= {1'b0, thr}) begin
            st_q   <= SA_ASLEEP;
            mode_q <= cfg_deep;
            idle_q <= '0;
          end else begin
            idle_q <= idle_nxt[IDLE_W-1:0];
          end
        end
        SA_ASLEEP: begin
          if (cnt_q != '1) cnt_q <= cnt_q + CNT_W'(1);
          if (req_valid) begin
            st_q   <= SA_WAKING;
            wake_q <= '0;
          end
        end
        SA_WAKING: begin
          if (wake_q == wake_last) begin
            st_q   <= SA_AWAKE;
            idle_q <= '0;
          end else begin
            wake_q <= wake_q + WAKE_W'(1);
          end
        end
        default: st_q <= SA_AWAKE;
      endcase
    end
  end

  assign awake       = (st_q == SA_AWAKE);
  assign sleep_light = (st_q == SA_ASLEEP) && !mode_q;
  assign sleep_deep  = (st_q == SA_ASLEEP) && mode_q;
  assign asleep_cnt  = cnt_q;

  // R2
  stay_asleep_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SA_ASLEEP && !req_valid) |=> (st_q == SA_ASLEEP));

  // R6
  wake_start_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SA_ASLEEP && req_valid) |=> (st_q == SA_WAKING));

  // R7
  mode_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q != SA_AWAKE) |=> $stable(mode_q));

  // R9
  asleep_count_chk: assert property (@(posedge clk) disable iff (rst)
    (st_q == SA_ASLEEP && cnt_q != '1) |=> (cnt_q == $past(cnt_q) + CNT_W'(1)));
endmodule

// File: rtl/sa_bank_arb.sv
module sa_bank_arb #(
  parameter int WIDTH = 4
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] cand,
  output logic [WIDTH-1:0] gnt
);
  // Lowest set bit wins.
  assign gnt = cand & (~cand + WIDTH'(1));

  // R8
  one_grant_chk: assert property (@(posedge clk) disable iff (rst)
    $onehot0(gnt));

  // R8
  grant_subset_chk: assert property (@(posedge clk) disable iff (rst)
    ((gnt & ~cand) == '0));
endmodule

// File: rtl/sa_cnt_readout.sv
module sa_cnt_readout #(
  parameter int NUM   = 8,
  parameter int CNT_W = 32,
  parameter int SEL_W = 3
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic [NUM-1:0][CNT_W-1:0] cnts,
  input  logic [SEL_W-1:0]          sel,
  output logic [CNT_W-1:0]          rd_data
);
  logic [CNT_W-1:0] picked;

  always_comb begin
    picked = '0;
    for (int i = 0; i < NUM; i++) begin
      if (sel == SEL_W'(i)) picked = cnts[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) rd_data <= '0;
    else     rd_data <= picked;
  end
endmodule

// File: rtl/sa_pwr_mgr.sv
module sa_pwr_mgr #(
  parameter int NUM_SUB    = 8,
  parameter int BANK_SIZE  = 4,
  parameter int MULT_W     = 4,
  parameter int CNT_W      = 32,
  parameter int LIGHT_WAKE = 3,
  parameter int DEEP_WAKE  = 200,
  parameter int SEL_W      = (NUM_SUB > 1) ? $clog2(NUM_SUB) : 1
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SUB-1:0] req_valid,
  output logic [NUM_SUB-1:0] req_ready,
  input  logic               cfg_deep,
  input  logic [MULT_W-1:0]  cfg_mult,
  output logic [NUM_SUB-1:0] sleep_light,
  output logic [NUM_SUB-1:0] sleep_deep,
  input  logic [SEL_W-1:0]   rd_sel,
  output logic [CNT_W-1:0]   rd_asleep
);
  localparam int NUM_BANK = NUM_SUB / BANK_SIZE;

  logic [NUM_SUB-1:0]            awake;
  logic [NUM_SUB-1:0][CNT_W-1:0] cnts;

  for (genvar s = 0; s < NUM_SUB; s++) begin : g_sub
    sa_pd_unit #(
      .MULT_W(MULT_W), .LIGHT_WAKE(LIGHT_WAKE),
      .DEEP_WAKE(DEEP_WAKE), .CNT_W(CNT_W)
    ) u_unit (
      .clk(clk), .rst(rst), .req_valid(req_valid[s]),
      .cfg_deep(cfg_deep), .cfg_mult(cfg_mult),
      .awake(awake[s]), .sleep_light(sleep_light[s]),
      .sleep_deep(sleep_deep[s]), .asleep_cnt(cnts[s])
    );
  end

  for (genvar b = 0; b < NUM_BANK; b++) begin : g_bank
    sa_bank_arb #(.WIDTH(BANK_SIZE)) u_arb (
      .clk(clk), .rst(rst),
      .cand(awake[b*BANK_SIZE +: BANK_SIZE] & req_valid[b*BANK_SIZE +: BANK_SIZE]),
      .gnt(req_ready[b*BANK_SIZE +: BANK_SIZE])
    );
  end

  sa_cnt_readout #(.NUM(NUM_SUB), .CNT_W(CNT_W), .SEL_W(SEL_W)) u_rd (
    .clk(clk), .rst(rst), .cnts(cnts), .sel(rd_sel), .rd_data(rd_asleep)
  );

  // R10
  ready_when_awake_chk: assert property (@(posedge clk) disable iff (rst)
    ((req_ready & (sleep_light | sleep_deep)) == '0));

  // R8
  ready_needs_valid_chk: assert property (@(posedge clk) disable iff (rst)
    ((req_ready & ~req_valid) == '0));
endmodule

// File: tb/sa_pwr_mgr_tb.sv
`timescale 1ns/1ps
module sa_pwr_mgr_tb;
  localparam int N  = 8;
  localparam int BS = 4;
  localparam int LW = 3;
  localparam int DW = 200;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic [N-1:0] req_valid = '0;
  logic [N-1:0] req_ready;
  logic         cfg_deep = 1'b0;
  logic [3:0]   cfg_mult = '0;
  logic [N-1:0] sleep_light, sleep_deep;
  logic [2:0]   rd_sel = '0;
  logic [31:0]  rd_asleep;

  int n_chk = 0;
  int n_bad = 0;
  bit mon_on = 1'b0;

  always #2.5 clk = ~clk;

  sa_pwr_mgr u_dut (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
    .cfg_deep(cfg_deep), .cfg_mult(cfg_mult), .sleep_light(sleep_light),
    .sleep_deep(sleep_deep), .rd_sel(rd_sel), .rd_asleep(rd_asleep)
  );

  // Reference model: 0 awake, 1 asleep, 2 waking
  int          m_st   [N];
  int          m_idle [N];
  int          m_wc   [N];
  bit          m_mode [N];
  logic [31:0] m_cnt  [N];
  logic [31:0] m_rd;

  always @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_st[i] = 0; m_idle[i] = 0; m_wc[i] = 0; m_mode[i] = 0; m_cnt[i] = 0;
      end
      m_rd = 0;
    end else begin
      m_rd = m_cnt[rd_sel];
      for (int i = 0; i < N; i++) begin
        int thr;
        thr = int'(cfg_mult) * (cfg_deep ? DW : LW);
        case (m_st[i])
          0: begin
            if (req_valid[i] || thr == 0) m_idle[i] = 0;
            else if (m_idle[i] + 1 >= thr) begin
              m_st[i] = 1; m_mode[i] = cfg_deep; m_idle[i] = 0;
            end else m_idle[i]++;
          end
          1: begin
            m_cnt[i]++;
            if (req_valid[i]) begin m_st[i] = 2; m_wc[i] = 0; end
          end
          default: begin
            if (m_wc[i] == (m_mode[i] ? DW : LW) - 1) m_st[i] = 0;
            else m_wc[i]++;
          end
        endcase
      end
    end
  end

  function automatic logic [N-1:0] exp_light();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (m_st[i] == 1) && !m_mode[i];
    return r;
  endfunction

  function automatic logic [N-1:0] exp_deep();
    logic [N-1:0] r;
    for (int i = 0; i < N; i++) r[i] = (m_st[i] == 1) && m_mode[i];
    return r;
  endfunction

  function automatic logic [N-1:0] exp_ready();
    logic [N-1:0] r;
    r = '0;
    for (int b = 0; b < N / BS; b++) begin
      bit taken;
      taken = 1'b0;
      for (int j = 0; j < BS; j++) begin
        int i;
        i = b * BS + j;
        if (!taken && m_st[i] == 0 && req_valid[i]) begin
          r[i] = 1'b1; taken = 1'b1;
        end
      end
    end
    return r;
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) begin @(posedge clk); #1; end
  endtask

  always @(negedge clk) begin
    if (mon_on && !rst) begin
      chk("R2 R4 R5 R7 sleep_light", 32'(sleep_light), 32'(exp_light()));
      chk("R3 R5 R7 sleep_deep", 32'(sleep_deep), 32'(exp_deep()));
      chk("R6 R8 R10 req_ready", 32'(req_ready), 32'(exp_ready()));
      chk("R9 rd_asleep", rd_asleep, m_rd);
    end
  end

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd4242));
    tick(3);
    chk("R1 sleep_light in reset", 32'(sleep_light), 0);
    chk("R1 sleep_deep in reset", 32'(sleep_deep), 0);
    chk("R1 ready in reset", 32'(req_ready), 0);
    chk("R1 rd_asleep in reset", rd_asleep, 0);
    rst = 1'b0;
    mon_on = 1'b1;
    tick(1);
    chk("R1 sleep after reset", 32'(sleep_light | sleep_deep), 0);

    // R2: light mode, multiplier 2 -> 6 idle edges
    cfg_mult = 4'd2;
    tick(5);
    chk("R2 one edge before limit", 32'(sleep_light), 0);
    tick(1);
    chk("R2 at limit", 32'(sleep_light), 32'hFF);

    // R6: wake-up timing in light mode
    req_valid[1] = 1'b1;
    tick(3);
    chk("R6 ready low while waking", 32'(req_ready[1]), 0);
    tick(1);
    chk("R6 ready after wake", 32'(req_ready[1]), 1);
    req_valid[1] = 1'b0;

    // R7: mode switch does not touch sleepers
    cfg_deep = 1'b1;
    tick(2);
    chk("R7 sleeper keeps light mode", 32'(sleep_light[0]), 1);
    req_valid[0] = 1'b1;
    tick(3);
    chk("R7 light latency kept, still low", 32'(req_ready[0]), 0);
    tick(1);
    chk("R7 light latency kept, ready", 32'(req_ready[0]), 1);
    req_valid[0] = 1'b0;

    // R3: deep mode, multiplier 1 -> 200 idle edges
    cfg_mult = 4'd1;
    tick(199);
    chk("R3 one edge before deep limit", 32'(sleep_deep[0]), 0);
    tick(1);
    chk("R3 at deep limit", 32'(sleep_deep[0]), 1);

    // R5: multiplier 0 disables sleep
    cfg_mult = 4'd0;
    req_valid = '1;
    tick(210);
    req_valid = '0;
    tick(500);
    chk("R5 nobody sleeps", 32'(sleep_light | sleep_deep), 0);

    // R8: full contention
    req_valid = '1;
    tick(1);
    chk("R8 lowest per bank", 32'(req_ready), 32'h11);
    req_valid = 8'hEE;
    tick(1);
    chk("R8 next lowest per bank", 32'(req_ready), 32'h22);
    req_valid = '0;

    // Random phase, checked each cycle against the model
    for (int k = 0; k < 20000; k++) begin
      if (k % 300 == 0) begin
        cfg_mult = 4'($urandom_range(0, 3));
        cfg_deep = ($urandom_range(0, 7) == 0);
      end
      for (int i = 0; i < N; i++)
        if ($urandom_range(0, 15) == 0) req_valid[i] = ~req_valid[i];
      rd_sel = 3'($urandom_range(0, N - 1));
      tick(1);
    end

    mon_on = 1'b0;
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule